// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two strobes that steer a multiplexed external bus on a controller whose machine cycle spans twelve oscillator clocks. An address-latch strobe (ALE, active high) tells external logic when to capture the low address byte. An active-low program-read strobe (PSEN) tells external program memory when to drive an opcode byte. The block also exports its position inside the machine cycle as a phase count, so neighbouring bus logic can align to it.

Five cycle-qualifier inputs are provided by the sequencer:
- an external code fetch,
- an external data access,
- a table read from code space,
- external-execution mode,
- a software bit that silences ALE.

All five are captured once per machine cycle, at the boundary, and they steer that whole cycle. In an ordinary cycle ALE pulses twice, at phases 0 and 6, for two clocks each. PSEN drops low for three clocks in each half-cycle, after ALE has fallen. A data-access cycle drops the late ALE pulse and both PSEN pulses. The silencing bit parks ALE high except in data-access or table-read cycles. External-execution mode overrides that bit.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase_o` is 0 while reset is held. It then advances by one on every clock and returns to 0 after 11.
- R2: The five qualifier inputs are sampled only on the clock edge that leaves phase 11, and they govern phases 0..11 of the cycle that follows. Input changes at any other phase have no effect on the strobes.
- R3: In a cycle with no data access and ALE not silenced, `ale_o` is 1 at phases 0, 1, 6 and 7 and 0 at all other phases.
- R4: In a data-access cycle that ALE is allowed in, `ale_o` is 1 only at phases 0 and 1. The pulse at phase 6 is dropped.
- R5: In a cycle with a code fetch and no data access, `psen_no` is 0 at phases 3, 4, 5, 9, 10 and 11 and 1 elsewhere. In a cycle without a code fetch, it stays 1.
- R6: In a data-access cycle, `psen_no` stays 1 for all twelve phases, even if a code fetch is flagged.
- R7: With the silencing bit set, external-execution mode clear, and neither a data access nor a table read, `ale_o` is held at 1 for the whole cycle.
- R8: With the silencing bit set, a table-read cycle pulses ALE as in R3, and a data-access cycle pulses ALE as in R4.
- R9: With external-execution mode set, the silencing bit has no effect, and ALE follows R3 or R4.
- R10: An asynchronous reset forces phase 0, `ale_o` = 1 and `psen_no` = 1, and clears the captured qualifiers. The next cycle therefore behaves as a plain cycle with no fetch, whatever the inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_fetch_i | input | 1 | Cycle fetches code from external memory |
| data_acc_i | input | 1 | Cycle accesses external data memory |
| movc_i | input | 1 | Cycle performs a table read from code space |
| ext_mode_i | input | 1 | Executing from external program memory |
| ale_off_i | input | 1 | Software bit that confines ALE to data/table cycles |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program read strobe, active low |
| phase_o | output | 4 | Oscillator phase within the machine cycle, 0..11 |

## Verification
The bench compares whole twelve-phase strobe patterns for every qualifier mix. This catches a design that drops the early ALE pulse instead of the late one, or that leaves PSEN active during a data access. It flips the qualifiers in the middle of a cycle, which would expose a design that samples them continuously instead of at the boundary. It covers the silencing bit with external execution, table reads and data accesses. A wrong gate there would park ALE high or leave it pulsing in the wrong cycles. A reset in the middle of a cycle shows whether the captured qualifiers are cleared or a stale fetch leaks into the following cycle.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Qualifiers captured once per machine cycle.
  typedef struct packed {
    logic fetch;    // external code fetch
    logic data;     // external data access
    logic movc;     // table read from code space
    logic ext;      // external execution mode
    logic ale_off;  // software ALE silencing bit
  } cyc_flags_t;

  localparam cyc_flags_t FLAGS_CLEAR = '0;

endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
  parameter int CYCLE_CLKS = 12,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_q_o,
  output logic [PH_W-1:0] phase_d_o,
  output logic            last_o
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLE_CLKS - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic            last;

  always_comb begin
    last    = (phase_q == LAST_PH);
    phase_d = last ? '0 : phase_q + PH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;
  assign last_o    = last;

  // R1
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == LAST_PH) |=> (phase_q == '0));

  // R1
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != LAST_PH) |=> (phase_q == $past(phase_q) + PH_W'(1)));

endmodule

// File: rtl/bus_cyc_latch.sv
module bus_cyc_latch
  import bus_strobe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  cyc_flags_t flags_i,
  output cyc_flags_t flags_q_o,
  output cyc_flags_t flags_d_o
);

  cyc_flags_t flags_q;
  cyc_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load_i) flags_d = flags_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= FLAGS_CLEAR;
    else         flags_q <= flags_d;
  end

  assign flags_q_o = flags_q;
  assign flags_d_o = flags_d;

  // R2
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(flags_q));

endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
  import bus_strobe_pkg::*;
#(
  parameter int CYCLE_CLKS  = 12,
  parameter int ALE_WIDTH   = 2,
  parameter int PSEN_OFFSET = 3,
  parameter int PSEN_WIDTH  = 3,
  parameter bit SKIP_LATE   = 1'b1,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] phase_d_i,
  input  cyc_flags_t      flags_d_i,
  output logic            ale_o,
  output logic            psen_no
);

  localparam int HALF     = CYCLE_CLKS / 2;
  localparam int PSEN_END = PSEN_OFFSET + PSEN_WIDTH;

  logic [PH_W-1:0] hpos;
  logic            late_half;
  logic            ale_win;
  logic            psen_win;
  logic            pulse_keep;
  logic            ale_gate;
  logic            ale_d;
  logic            psen_n_d;
  logic            ale_q;
  logic            psen_n_q;

  always_comb begin
    late_half = (phase_d_i >= PH_W'(HALF));
    hpos      = late_half ? phase_d_i - PH_W'(HALF) : phase_d_i;
    ale_win   = (hpos < PH_W'(ALE_WIDTH));
    psen_win  = (hpos >= PH_W'(PSEN_OFFSET)) && (hpos < PH_W'(PSEN_END));
  end

  // Which of the two address pulses a data cycle gives up.
  generate
    if (SKIP_LATE) begin : g_skip_late
      always_comb pulse_keep = !(flags_d_i.data && late_half);
    end else begin : g_skip_early
      always_comb pulse_keep = !(flags_d_i.data && !late_half);
    end
  endgenerate

  always_comb begin
    ale_gate = flags_d_i.ext || !flags_d_i.ale_off ||
               flags_d_i.data || flags_d_i.movc;
    ale_d    = ale_gate ? (ale_win && pulse_keep) : 1'b1;
    psen_n_d = !(flags_d_i.fetch && !flags_d_i.data && psen_win);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q    <= 1'b1;
      psen_n_q <= 1'b1;
    end else begin
      ale_q    <= ale_d;
      psen_n_q <= psen_n_d;
    end
  end

  assign ale_o   = ale_q;
  assign psen_no = psen_n_q;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int CYCLE_CLKS  = 12,
  parameter int ALE_WIDTH   = 2,
  parameter int PSEN_OFFSET = 3,
  parameter int PSEN_WIDTH  = 3,
  parameter bit SKIP_LATE   = 1'b1,
  localparam int PH_W = $clog2(CYCLE_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_fetch_i,
  input  logic            data_acc_i,
  input  logic            movc_i,
  input  logic            ext_mode_i,
  input  logic            ale_off_i,
  output logic            ale_o,
  output logic            psen_no,
  output logic [PH_W-1:0] phase_o
);

  localparam int HALF = CYCLE_CLKS / 2;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic            cyc_last;
  cyc_flags_t      flags_in;
  cyc_flags_t      flags_q;
  cyc_flags_t      flags_d;

  always_comb begin
    flags_in.fetch   = prog_fetch_i;
    flags_in.data    = data_acc_i;
    flags_in.movc    = movc_i;
    flags_in.ext     = ext_mode_i;
    flags_in.ale_off = ale_off_i;
  end

  bus_phase_ctr #(
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_q_o (phase_q),
    .phase_d_o (phase_d),
    .last_o    (cyc_last)
  );

  bus_cyc_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cyc_last),
    .flags_i   (flags_in),
    .flags_q_o (flags_q),
    .flags_d_o (flags_d)
  );

  bus_strobe_dec #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .ALE_WIDTH  (ALE_WIDTH),
    .PSEN_OFFSET(PSEN_OFFSET),
    .PSEN_WIDTH (PSEN_WIDTH),
    .SKIP_LATE  (SKIP_LATE)
  ) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_d_i (phase_d),
    .flags_d_i (flags_d),
    .ale_o     (ale_o),
    .psen_no   (psen_no)
  );

  assign phase_o = phase_q;

  // R6
  data_no_psen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.data |-> psen_no);

  // R5
  psen_needs_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> flags_q.fetch);

  // R4
  data_late_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SKIP_LATE && flags_q.data && (phase_q >= PH_W'(HALF))) |-> !ale_o);

  // R7
  ale_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q.ale_off && !flags_q.ext && !flags_q.data && !flags_q.movc) |-> ale_o);

  // R9
  ext_ale_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q.ext && (phase_q == PH_W'(ALE_WIDTH))) |-> !ale_o);

endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       fetch, data, movc, ext, aoff;
  logic       ale;
  logic       psen_n;
  logic [3:0] phase;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  bus_strobe_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .prog_fetch_i(fetch),
    .data_acc_i  (data),
    .movc_i      (movc),
    .ext_mode_i  (ext),
    .ale_off_i   (aoff),
    .ale_o       (ale),
    .psen_no     (psen_n),
    .phase_o     (phase)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector: {fetch,data,movc,ext,ale_off, ALE pattern, PSEN_n pattern};
  // pattern bit p is the expected level at phase p.
  localparam logic [28:0] VECS [0:7] = '{
    {5'b10000, 12'h0C3, 12'h1C7},  // R3 R5 plain fetch cycle
    {5'b11000, 12'h003, 12'hFFF},  // R4 R6 data cycle with fetch flagged
    {5'b00000, 12'h0C3, 12'hFFF},  // R3 R5 no fetch
    {5'b00001, 12'hFFF, 12'hFFF},  // R7 silenced
    {5'b00101, 12'h0C3, 12'hFFF},  // R8 silenced, table read
    {5'b01001, 12'h003, 12'hFFF},  // R8 silenced, data access
    {5'b10011, 12'h0C3, 12'h1C7},  // R9 silenced but external execution
    {5'b01000, 12'h003, 12'hFFF}   // R4 R6 data, no fetch
  };

  string vreq [0:7];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] f);
    {fetch, data, movc, ext, aoff} = f;
  endtask

  task automatic to_last_phase();
    while (phase != 4'd11) @(negedge clk);
  endtask

  // Check one full cycle, phases 0..11, starting at the next negedge.
  task automatic run_cycle(input logic [11:0] ap, input logic [11:0] pp, input string tag);
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      chk({"R1 phase ", tag}, int'(phase), p);
      chk({"ALE ", tag}, int'(ale), int'(ap[p]));
      chk({"PSEN ", tag}, int'(psen_n), int'(pp[p]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vreq[0] = "R3/R5"; vreq[1] = "R4/R6"; vreq[2] = "R3/R5"; vreq[3] = "R7";
    vreq[4] = "R8";    vreq[5] = "R8";    vreq[6] = "R9";    vreq[7] = "R4/R6";
    rst_n = 1'b0;
    drive(5'b00000);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 phase", int'(phase), 0);
    chk("R10 ale", int'(ale), 1);
    chk("R10 psen", int'(psen_n), 1);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < 8; v++) begin
      to_last_phase();
      drive(VECS[v][28:24]);
      run_cycle(VECS[v][23:12], VECS[v][11:0], vreq[v]);
    end

    // R2: mid-cycle changes are ignored until the boundary
    to_last_phase();
    drive(5'b10000);
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      chk("R2 ALE held", int'(ale), int'(VECS[0][12 + p]));
      chk("R2 PSEN held", int'(psen_n), int'(VECS[0][p]));
      if (p == 4) drive(5'b01001);
    end
    run_cycle(12'h003, 12'hFFF, "R2 next cycle");

    // R10: reset in mid-cycle clears the captured fetch
    to_last_phase();
    drive(5'b10000);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid phase", int'(phase), 0);
    chk("R10 mid ale", int'(ale), 1);
    chk("R10 mid psen", int'(psen_n), 1);
    rst_n = 1'b1;
    for (int p = 1; p < 12; p++) begin
      @(negedge clk);
      chk("R10 post phase", int'(phase), p);
      chk("R10 post ale", int'(ale), int'(VECS[0][12 + p]));
      chk("R10 post psen", int'(psen_n), 1);
    end
    run_cycle(12'h0C3, 12'h1C7, "R5 after reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule